// File: doc/BRIEF.md
# Serial Shift Slice with Shadow Swap

This block is a single bit-serial shift lane. A reloadable down-counter sets the shift rate. Each time the counter expires, a 32-bit live data word moves one place toward bit 0. The sampled serial input enters at the top, and the lowest bit drives the serial output. A second, 8-bit position counter counts these shift events. When it expires, the live word and a 32-bit shadow word trade places in one cycle. Software can therefore prepare or collect a whole word while the next one is still streaming.

Software controls the slice through a plain register port with one write strobe and a combinational read. Two controls start and stop the counter: a write-one-to-start control and a write-one-to-stop control. Each exchange also produces a one-cycle pulse, which is meant to serve as an interrupt source.

Top module: `shift_slice`

## Requirements
- R1: After reset, every register reads zero, the slice is stopped, `ser_out` is 0 and `swap_pulse` is 0.
- R2: A write with bit 0 set to address 5 starts the slice, and a write with bit 0 set to address 6 stops it. A write with bit 0 clear to either address has no effect. Reading address 5 returns the run state in bit 0, and reading address 6 returns zero.
- R3: While the slice runs and its count is not zero, the count (address 1) drops by one on every clock.
- R4: A running slice whose count is zero reloads the count from the preset (address 0) on the next clock, so the count repeats with a period of preset+1 clocks.
- R5: On each clock where a running slice has a zero count (a shift event), the data word (address 3) shifts right by one place, and bit 31 takes the value `ser_in` has in that cycle.
- R6: `ser_out` always equals bit 0 of the data word.
- R7: The position register (address 2) holds the current value in bits 7:0 and the reload value in bits 15:8. On a shift event the current value drops by one. On a shift event where the current value is zero, it instead reloads from the reload value and an exchange takes place. The position register does not change on any other clock.
- R8: In an exchange, the data word takes the old shadow word (address 4), and the shadow word takes the data word as shifted in that same cycle.
- R9: `swap_pulse` is high for exactly the one cycle that follows the clock edge on which an exchange took place.
- R10: While the slice is stopped, the count, data, shadow and position registers hold their values whatever `ser_in` does. A write to any of them is visible on the very next read.
- R11: When a software write and a slice update hit the same register in the same cycle, the software write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 preset, 1 count, 2 position, 3 data, 4 shadow, 5 start, 6 stop) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address, same map as `wr_addr` |
| rd_data | output | 32 | Combinational read data |
| ser_in | input | 1 | Serial data input, sampled on shift events |
| ser_out | output | 1 | Serial data output, equal to data bit 0 |
| swap_pulse | output | 1 | One-cycle pulse after each exchange |

## Verification
The bound checker watches the cycle-level rules on every clock. These are the count decrementing and reloading, the one-place shift on each shift event, the exchange moving the shifted word into the shadow, the position value holding between shift events, and everything freezing while the slice is stopped. The directed scenarios cover what depends on longer sequences or on the register map. These are the reset values, the write-one start and stop semantics, the serial output pattern over several shifts, the exact clock on which the exchange and its pulse appear, and a software write winning over a shift in the same cycle.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef enum logic [2:0] {
    A_PRESET = 3'd0,
    A_COUNT  = 3'd1,
    A_POS    = 3'd2,
    A_DATA   = 3'd3,
    A_SHADOW = 3'd4,
    A_RUNSET = 3'd5,
    A_RUNCLR = 3'd6
  } slice_addr_e;
endpackage

// File: rtl/slice_timer.sv
module slice_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             zero_evt
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] p);
    return (c == '0) ? p : c - 1'b1;
  endfunction

  assign zero_evt = run && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (ld)  count <= ld_val;
    else if (run) count <= next_count(count, preset);
  end
endmodule

// File: rtl/slice_pos.sv
module slice_pos #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             ld,
  input  logic [POS_W-1:0] ld_cur,
  input  logic [POS_W-1:0] ld_rel,
  output logic [POS_W-1:0] cur,
  output logic [POS_W-1:0] rel,
  output logic             swap_evt
);
  function automatic logic [POS_W-1:0] next_pos(input logic [POS_W-1:0] c,
                                                input logic [POS_W-1:0] r);
    return (c == '0) ? r : c - 1'b1;
  endfunction

  assign swap_evt = step && (cur == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
      rel <= '0;
    end else if (ld) begin
      cur <= ld_cur;
      rel <= ld_rel;
    end else if (step) begin
      cur <= next_pos(cur, rel);
    end
  end
endmodule

// File: rtl/slice_data.sv
module slice_data #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              swap_en,
  input  logic              ser_in,
  input  logic              ld_data,
  input  logic              ld_shadow,
  input  logic [DATA_W-1:0] ld_val,
  output logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] shadow
);
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] d,
                                                 input logic b);
    return {b, d[DATA_W-1:1]};
  endfunction

  logic [DATA_W-1:0] shifted;
  assign shifted = shift_in(data, ser_in);

  always_ff @(posedge clk) begin
    if (!rst_n)        data <= '0;
    else if (ld_data)  data <= ld_val;
    else if (swap_en)  data <= shadow;
    else if (shift_en) data <= shifted;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         shadow <= '0;
    else if (ld_shadow) shadow <= ld_val;
    else if (swap_en)   shadow <= shifted;
  end
endmodule

// File: rtl/shift_slice.sv
module shift_slice #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int POS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              swap_pulse
);
  import slice_pkg::*;

  localparam int POSR_W = 2 * POS_W;

  logic             run_q;
  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] cnt_q;
  logic             zero_evt;
  logic             swap_evt;
  logic [POS_W-1:0] pos_cur;
  logic [POS_W-1:0] pos_rel;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] shadow_q;

  logic wr_preset, wr_count, wr_pos, wr_data_w, wr_shadow, wr_set, wr_clr;
  assign wr_preset = wr_en && (wr_addr == A_PRESET);
  assign wr_count  = wr_en && (wr_addr == A_COUNT);
  assign wr_pos    = wr_en && (wr_addr == A_POS);
  assign wr_data_w = wr_en && (wr_addr == A_DATA);
  assign wr_shadow = wr_en && (wr_addr == A_SHADOW);
  assign wr_set    = wr_en && (wr_addr == A_RUNSET) && wr_data[0];
  assign wr_clr    = wr_en && (wr_addr == A_RUNCLR) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      preset_q   <= '0;
      swap_pulse <= 1'b0;
    end else begin
      if (wr_clr)      run_q <= 1'b0;
      else if (wr_set) run_q <= 1'b1;
      if (wr_preset) preset_q <= wr_data[CNT_W-1:0];
      swap_pulse <= swap_evt;
    end
  end

  slice_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run_q),
    .ld(wr_count), .ld_val(wr_data[CNT_W-1:0]), .preset(preset_q),
    .count(cnt_q), .zero_evt(zero_evt)
  );

  slice_pos #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(zero_evt),
    .ld(wr_pos), .ld_cur(wr_data[POS_W-1:0]), .ld_rel(wr_data[POSR_W-1:POS_W]),
    .cur(pos_cur), .rel(pos_rel), .swap_evt(swap_evt)
  );

  slice_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .shift_en(zero_evt), .swap_en(swap_evt),
    .ser_in(ser_in), .ld_data(wr_data_w), .ld_shadow(wr_shadow), .ld_val(wr_data),
    .data(data_q), .shadow(shadow_q)
  );

  assign ser_out = data_q[0];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_PRESET: rd_data[CNT_W-1:0] = preset_q;
      A_COUNT:  rd_data[CNT_W-1:0] = cnt_q;
      A_POS:    rd_data[POSR_W-1:0] = {pos_rel, pos_cur};
      A_DATA:   rd_data = data_q;
      A_SHADOW: rd_data = shadow_q;
      A_RUNSET: rd_data[0] = run_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/slice_chk.sv
module slice_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int POS_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic              ser_in,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  preset,
  input logic              zero_evt,
  input logic              swap_evt,
  input logic [POS_W-1:0]  pos_cur,
  input logic [DATA_W-1:0] data,
  input logic [DATA_W-1:0] shadow,
  input logic              swap_pulse
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (wr_addr == 3'd1);

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0 && !cnt_wr) |=> (cnt == $past(cnt) - 1'b1));

  // R4
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !cnt_wr) |=> (cnt == $past(preset)));

  // R5
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !swap_evt && !wr_en) |=>
      (data == {$past(ser_in), $past(data[DATA_W-1:1])}));

  // R7
  pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_evt && !wr_en) |=> $stable(pos_cur));

  // R7
  swap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |-> zero_evt);

  // R8
  swap_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_evt && !wr_en) |=>
      (data == $past(shadow) && shadow == {$past(ser_in), $past(data[DATA_W-1:1])}));

  // R9
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pulse |-> $past(zero_evt));

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=>
      ($stable(cnt) && $stable(data) && $stable(shadow) && $stable(pos_cur)));
endmodule

bind shift_slice slice_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .ser_in(ser_in),
  .run(run_q), .cnt(cnt_q), .preset(preset_q), .zero_evt(zero_evt),
  .swap_evt(swap_evt), .pos_cur(pos_cur), .data(data_q), .shadow(shadow_q),
  .swap_pulse(swap_pulse)
);

// File: tb/shift_slice_bench.sv
`timescale 1ns/100ps
module shift_slice_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ser_in = 1'b0;
  logic        ser_out;
  logic        swap_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  shift_slice u_shift_slice (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ser_in(ser_in), .ser_out(ser_out),
    .swap_pulse(swap_pulse)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  function automatic logic [31:0] sh(input logic [31:0] d, input logic b);
    return {b, d[31:1]};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check("R1 reg reset", v, 32'h0);
    end
    check("R1 ser_out reset", {31'b0, ser_out}, 32'h0);
    check("R1 pulse reset", {31'b0, swap_pulse}, 32'h0);
  endtask

  task automatic t_runctl;
    logic [31:0] v;
    wr(3'd5, 32'h0); rd(3'd5, v); check("R2 start with bit0 clear", v, 32'h0);
    wr(3'd5, 32'h1); rd(3'd5, v); check("R2 start", v, 32'h1);
    rd(3'd6, v); check("R2 stop address reads zero", v, 32'h0);
    wr(3'd6, 32'h0); rd(3'd5, v); check("R2 stop with bit0 clear", v, 32'h1);
    wr(3'd6, 32'h1); rd(3'd5, v); check("R2 stop", v, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(3'd0, 32'd3); wr(3'd1, 32'd5); wr(3'd2, 32'h0000_000A); wr(3'd3, 32'h0);
    ser_in = 1'b1;
    wr(3'd5, 32'h1);
    repeat (6) @(negedge clk);
    wr(3'd6, 32'h1);
    // seven running edges from 5 with preset 3: 4,3,2,1,0,3,2
    rd(3'd1, v); check("R3 R4 count after reload", v, 32'd2);
    rd(3'd3, v); check("R5 single shift of a one", v, 32'h8000_0000);
    rd(3'd2, v); check("R7 position step", v, 32'h0000_0009);
  endtask

  task automatic t_shift;
    logic [31:0] v, m;
    logic [3:0]  pat;
    pat = 4'b1011;
    m = 32'h0000_0005;
    wr(3'd0, 32'd0); wr(3'd1, 32'd0); wr(3'd2, 32'd200); wr(3'd3, m);
    check("R6 ser_out follows loaded bit0", {31'b0, ser_out}, {31'b0, m[0]});
    wr(3'd5, 32'h1);
    for (int i = 0; i < 4; i++) begin
      ser_in = pat[i];
      @(negedge clk);
      m = sh(m, pat[i]);
      check("R6 ser_out per shift", {31'b0, ser_out}, {31'b0, m[0]});
    end
    ser_in = 1'b0;
    wr(3'd6, 32'h1);
    m = sh(m, 1'b0);
    rd(3'd3, v); check("R5 data after five shifts", v, m);
    rd(3'd2, v); check("R7 position after five events", v, 32'd195);
  endtask

  task automatic t_swap;
    logic [31:0] v, a, b;
    int pulses;
    a = 32'h1234_5678; b = 32'hCAFE_F00D;
    pulses = 0;
    ser_in = 1'b0;
    wr(3'd0, 32'd0); wr(3'd1, 32'd0); wr(3'd2, 32'h0000_0102);
    wr(3'd3, a); wr(3'd4, b);
    wr(3'd5, 32'h1);
    check("R9 no pulse before exchange", {31'b0, swap_pulse}, 32'h0);
    @(negedge clk); check("R9 no pulse edge 1", {31'b0, swap_pulse}, 32'h0);
    @(negedge clk); check("R9 no pulse edge 2", {31'b0, swap_pulse}, 32'h0);
    @(negedge clk); check("R9 pulse after exchange", {31'b0, swap_pulse}, 32'h1);
    wr(3'd6, 32'h1);
    check("R9 pulse lasts one cycle", {31'b0, swap_pulse}, 32'h0);
    rd(3'd4, v); check("R8 shadow holds shifted word", v, sh(sh(sh(a, 1'b0), 1'b0), 1'b0));
    rd(3'd3, v); check("R8 data took shadow then shifted", v, sh(b, 1'b0));
    check("R6 ser_out after exchange", {31'b0, ser_out}, {31'b0, v[0]});
    rd(3'd2, v); check("R7 position reloaded then stepped", v, 32'h0000_0100);
    repeat (4) begin
      @(negedge clk);
      if (swap_pulse) pulses++;
    end
    check("R9 no pulse while stopped", pulses, 0);
  endtask

  task automatic t_hold;
    logic [31:0] c0, d0, p0, s0, v;
    rd(3'd1, c0); rd(3'd3, d0); rd(3'd2, p0); rd(3'd4, s0);
    for (int i = 0; i < 8; i++) begin
      ser_in = i[0];
      @(negedge clk);
    end
    rd(3'd1, v); check("R10 count holds", v, c0);
    rd(3'd3, v); check("R10 data holds", v, d0);
    rd(3'd2, v); check("R10 position holds", v, p0);
    rd(3'd4, v); check("R10 shadow holds", v, s0);
    wr(3'd3, 32'h0000_55AA); rd(3'd3, v); check("R10 data write visible", v, 32'h0000_55AA);
    wr(3'd1, 32'h0000_0077); rd(3'd1, v); check("R10 count write visible", v, 32'h0000_0077);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(3'd0, 32'd0); wr(3'd1, 32'd0); wr(3'd2, 32'd100);
    ser_in = 1'b1;
    wr(3'd5, 32'h1);
    @(negedge clk);
    wr(3'd3, 32'hDEAD_BEEF);
    wr(3'd6, 32'h1);
    rd(3'd3, v); check("R11 write wins over shift", v, sh(32'hDEAD_BEEF, 1'b1));
    rd(3'd1, v); check("R11 count stays at zero with preset zero", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_runctl;
    t_count;
    t_shift;
    t_swap;
    t_hold;
    t_priority;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule